// File: doc/BRIEF.md
# Socket Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses coming from four protocol sockets and from the shared network logic. Each pulse is latched into a sticky status bit. Every socket has its own five-bit status word. A common status byte holds two network-level flags and one summary bit per socket, where the summary is the OR of that socket's status word. A mask byte selects which summary bits and which network flags may pull the active-low interrupt line. The host clears a status bit by writing a 1 to it. If a new event arrives in the same cycle, the event wins.

The unit also contains one retransmission timer. Its period is given in units of a base tick, nominally 100 us, so a period of 4000 (0x0FA0) lasts 400 ms. The host starts the timer on behalf of one socket. When the programmed number of ticks has elapsed, the timer sets that socket's timeout bit. The cycle length of the tick is a parameter, `TICK_CYC`. At 25 MHz it is 2500 cycles.

Top module: `sock_irq_unit`

## Requirements
- R1: After reset every socket status word and the common status byte are zero, the mask is zero and `int_n_o` is 1.
- R2: A pulse on `sock_evt_i[n*5+b]` sets bit b of socket n's status, and the bit stays set until it is cleared. The bit positions are: 0 connection established, 1 disconnect, 2 data received, 3 timeout, 4 send complete.
- R3: A write with `host_addr_i` = 2+n clears each bit of socket n's status whose `host_wdata_i` bit is 1. Bits written as 0 are left unchanged.
- R4: When a status bit receives an event and a clear in the same cycle, the bit ends up set.
- R5: `net_evt_i[0]` (destination unreachable) sets common bit 6 and `net_evt_i[1]` (address conflict) sets common bit 7. Both bits are sticky. A write to address 0 clears them, one bit per 1 in `host_wdata_i[7:6]`.
- R6: Common bit n (n < 4) is 1 exactly when socket n's status word is nonzero. Writes to these bits have no effect.
- R7: A write to address 1 loads the mask with `host_wdata_i`. Mask bit n enables socket n's summary bit, bit 6 enables the unreachable flag and bit 7 enables the conflict flag.
- R8: `int_n_o` is 0 in the cycle after any common status bit whose mask bit is 1 is set. Otherwise it is 1.
- R9: A `rto_start_i` pulse with period p > 0 sets the timeout bit (bit 3) of socket `rto_sock_i` at the p*TICK_CYC-th clock edge after the start edge, and not before.
- R10: `rto_stop_i` cancels a running timer. A new start restarts the count and replaces the target socket. A start with period 0 leaves the timer idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sock_evt_i | input | 20 | Per-socket event pulses, 5 per socket |
| net_evt_i | input | 2 | Network events: [0] unreachable, [1] conflict |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 3 | Host register select: 0 common, 1 mask, 2+n socket n |
| host_wdata_i | input | 8 | Host write data |
| rto_start_i | input | 1 | Start or restart the retransmission timer |
| rto_stop_i | input | 1 | Cancel the retransmission timer |
| rto_sock_i | input | 2 | Socket that the timer reports its timeout to |
| rto_period_i | input | 16 | Timer period in base ticks |
| sock_stat_o | output | 20 | Socket status words, socket n at [n*5+4:n*5] |
| com_stat_o | output | 8 | Common status byte |
| mask_o | output | 8 | Interrupt mask |
| int_n_o | output | 1 | Active-low interrupt |

## Verification
The bench walks every socket through every event bit, one at a time. This sets the bit positions apart and shows that no bit leaks into a neighbouring socket. Each bit is then cleared twice: once with all the other bits of the byte written as 1, and once with only its own bit. This separates a true write-one-to-clear from a whole-register clear, and a same-cycle event plus clear shows that the event has priority. A fixed mix of set status bits is held while all 256 mask values are swept, which exposes any wrong mask-to-source pairing on the interrupt output. The timer is run with periods 1 to 4 against different sockets, with a check on every cycle so that an expiry one tick early or late is caught, and is then stopped, restarted and started with a zero period.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  // Socket status bit positions
  localparam int EVW         = 5;
  localparam int EVT_CON     = 0;
  localparam int EVT_DIS     = 1;
  localparam int EVT_RECV    = 2;
  localparam int EVT_TMO     = 3;
  localparam int EVT_SENDOK  = 4;
  // Common status byte
  localparam int REG_W       = 8;
  localparam int COM_UNREACH = 6;
  localparam int COM_CONFLICT = 7;
  // Host register select
  localparam int ADDR_COM    = 0;
  localparam int ADDR_MASK   = 1;
  localparam int ADDR_SOCK0  = 2;
endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/sirq_stat_reg.sv
// Sticky status bits: an event sets, a host write of 1 clears, the event wins.
module sirq_stat_reg #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_d, stat_q;

  always_comb begin
    stat_d = evt_i | (stat_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/sirq_rto_timer.sv
// Retransmission timer: a prescaler makes base ticks, and a down-counter counts the period.
module sirq_rto_timer #(
  parameter int PER_W    = 16,
  parameter int TICK_CYC = 2500,
  parameter int SOCK_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SOCK_W-1:0] sock_i,
  input  logic [PER_W-1:0]  period_i,
  output logic              expire_o,
  output logic [SOCK_W-1:0] own_o
);
  localparam int PRE_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYC - 1);

  logic              act_d, act_q;
  logic [PRE_W-1:0]  pre_d, pre_q;
  logic [PER_W-1:0]  cnt_d, cnt_q;
  logic [SOCK_W-1:0] own_d, own_q;
  logic              tick, expire;

  always_comb begin
    act_d  = act_q;
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    own_d  = own_q;
    expire = 1'b0;
    tick   = act_q && (pre_q == PRE_LAST);
    if (act_q) begin
      if (tick) begin
        pre_d = '0;
        cnt_d = cnt_q - PER_W'(1);
        if (cnt_q == PER_W'(1)) begin
          act_d  = 1'b0;
          expire = !start_i && !stop_i;
        end
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
    if (stop_i) act_d = 1'b0;
    if (start_i) begin
      act_d = |period_i;
      pre_d = '0;
      cnt_d = period_i;
      own_d = sock_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
      own_q <= '0;
    end else begin
      act_q <= act_d;
      pre_q <= pre_d;
      cnt_q <= cnt_d;
      own_q <= own_d;
    end
  end

  assign expire_o = expire;
  assign own_o    = own_q;
endmodule

// File: rtl/sock_irq_unit.sv
module sock_irq_unit #(
  parameter int NSOCK    = 4,
  parameter int PER_W    = 16,
  parameter int TICK_CYC = 2500
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NSOCK*sirq_pkg::EVW-1:0] sock_evt_i,
  input  logic [1:0]                    net_evt_i,
  input  logic                          host_we_i,
  input  logic [$clog2(NSOCK+2)-1:0]    host_addr_i,
  input  logic [sirq_pkg::REG_W-1:0]    host_wdata_i,
  input  logic                          rto_start_i,
  input  logic                          rto_stop_i,
  input  logic [((NSOCK>1)?$clog2(NSOCK):1)-1:0] rto_sock_i,
  input  logic [PER_W-1:0]              rto_period_i,
  output logic [NSOCK*sirq_pkg::EVW-1:0] sock_stat_o,
  output logic [sirq_pkg::REG_W-1:0]    com_stat_o,
  output logic [sirq_pkg::REG_W-1:0]    mask_o,
  output logic                          int_n_o
);
  import sirq_pkg::*;

  // Summary bits occupy [NSOCK-1:0] of the common byte, so NSOCK must not exceed 6.
  localparam int ADDR_W = $clog2(NSOCK + 2);
  localparam int SOCK_W = (NSOCK > 1) ? $clog2(NSOCK) : 1;

  logic              rst_n_sync;
  logic              tmo_exp;
  logic [SOCK_W-1:0] tmo_own;
  logic [EVW-1:0]    sock_q [NSOCK];
  logic [1:0]        net_q;
  logic [1:0]        net_clr;
  logic [REG_W-1:0]  mask_d, mask_q;
  logic [REG_W-1:0]  com_stat;
  logic              int_n_d, int_n_q;
  logic              mask_en;

  sirq_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  sirq_rto_timer #(
    .PER_W    (PER_W),
    .TICK_CYC (TICK_CYC),
    .SOCK_W   (SOCK_W)
  ) u_rto (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .start_i  (rto_start_i),
    .stop_i   (rto_stop_i),
    .sock_i   (rto_sock_i),
    .period_i (rto_period_i),
    .expire_o (tmo_exp),
    .own_o    (tmo_own)
  );

  for (genvar n = 0; n < NSOCK; n++) begin : g_sock
    logic [EVW-1:0] evt, clr;
    always_comb begin
      evt = sock_evt_i[n*EVW +: EVW];
      if (tmo_exp && (tmo_own == SOCK_W'(n))) evt[EVT_TMO] = 1'b1;
      clr = (host_we_i && (host_addr_i == ADDR_W'(ADDR_SOCK0 + n)))
            ? host_wdata_i[EVW-1:0] : '0;
    end
    sirq_stat_reg #(.W(EVW)) u_stat (
      .clk_i  (clk_i),
      .rst_ni (rst_n_sync),
      .evt_i  (evt),
      .clr_i  (clr),
      .stat_o (sock_q[n])
    );
    assign sock_stat_o[n*EVW +: EVW] = sock_q[n];
  end

  // Network flags: bit 0 unreachable, bit 1 conflict
  always_comb begin
    net_clr = (host_we_i && (host_addr_i == ADDR_W'(ADDR_COM)))
              ? {host_wdata_i[COM_CONFLICT], host_wdata_i[COM_UNREACH]} : 2'b00;
  end

  sirq_stat_reg #(.W(2)) u_net (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .evt_i  (net_evt_i),
    .clr_i  (net_clr),
    .stat_o (net_q)
  );

  always_comb begin
    com_stat = '0;
    com_stat[COM_UNREACH]  = net_q[0];
    com_stat[COM_CONFLICT] = net_q[1];
    for (int i = 0; i < NSOCK; i++) com_stat[i] = |sock_q[i];
  end

  // Mask register with explicit enable
  always_comb begin
    mask_en = host_we_i && (host_addr_i == ADDR_W'(ADDR_MASK));
    mask_d  = mask_en ? host_wdata_i : mask_q;
    int_n_d = ~|(com_stat & mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      mask_q  <= '0;
      int_n_q <= 1'b1;
    end else begin
      mask_q  <= mask_d;
      int_n_q <= int_n_d;
    end
  end

  assign com_stat_o = com_stat;
  assign mask_o     = mask_q;
  assign int_n_o    = int_n_q;
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk #(
  parameter int NSOCK  = 4,
  parameter int ADDR_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          host_we,
  input logic [ADDR_W-1:0]             host_addr,
  input logic [7:0]                    host_wdata,
  input logic [NSOCK*sirq_pkg::EVW-1:0] sock_evt,
  input logic [NSOCK*sirq_pkg::EVW-1:0] sock_stat,
  input logic [7:0]                    com_stat,
  input logic [7:0]                    mask,
  input logic                          int_n
);
  assert_stat_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |=> ((~sock_stat & $past(sock_stat)) == '0));

  assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|sock_evt) |=> ((sock_stat & $past(sock_evt)) == $past(sock_evt)));

  assert_net_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |=> ((~com_stat[7:6] & $past(com_stat[7:6])) == 2'b00));

  assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && (host_addr == ADDR_W'(sirq_pkg::ADDR_MASK))) |=> (mask == $past(host_wdata)));

  assert_irq_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(com_stat & mask)) |=> !int_n);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 8'h00) |=> int_n);
endmodule

bind sock_irq_unit sirq_chk #(
  .NSOCK  (NSOCK),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk        (clk_i),
  .rst_n      (rst_n_sync),
  .host_we    (host_we_i),
  .host_addr  (host_addr_i),
  .host_wdata (host_wdata_i),
  .sock_evt   (sock_evt_i),
  .sock_stat  (sock_stat_o),
  .com_stat   (com_stat_o),
  .mask       (mask_o),
  .int_n      (int_n_o)
);

// File: tb/sock_irq_unit_tb_top.sv
`timescale 1ns/1ps
module sock_irq_unit_tb_top;
  localparam int NS  = 4;
  localparam int TK  = 3;
  localparam int PW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [19:0]   sevt = '0;
  logic [1:0]    nevt = '0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic          start = 1'b0, stop = 1'b0;
  logic [1:0]    rsock = '0;
  logic [PW-1:0] period = '0;
  logic [19:0]   sstat;
  logic [7:0]    cstat, mask;
  logic          int_n;

  int n_chk = 0, n_fail = 0;

  logic [4:0] m_sock [NS];
  logic [1:0] m_net;
  logic [7:0] m_mask;
  logic       m_int_n;
  int         rto_left, rto_own;

  always #2.5 clk = ~clk;

  sock_irq_unit #(.NSOCK(NS), .PER_W(PW), .TICK_CYC(TK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sock_evt_i(sevt), .net_evt_i(nevt),
    .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wdata),
    .rto_start_i(start), .rto_stop_i(stop), .rto_sock_i(rsock),
    .rto_period_i(period), .sock_stat_o(sstat), .com_stat_o(cstat),
    .mask_o(mask), .int_n_o(int_n));

  function automatic logic [7:0] exp_com();
    logic [7:0] c = '0;
    c[6] = m_net[0];
    c[7] = m_net[1];
    for (int n = 0; n < NS; n++) c[n] = |m_sock[n];
    return c;
  endfunction

  task automatic idle();
    sevt = '0; nevt = '0; we = 1'b0; addr = '0; wdata = '0;
    start = 1'b0; stop = 1'b0; rsock = '0; period = '0;
  endtask

  // One clock edge: update the model from the requirements, then advance.
  task automatic step();
    logic       any;
    int         tsock;
    logic [4:0] ev, clr;
    any   = |(exp_com() & m_mask);
    tsock = -1;
    if (start || stop) begin
      if (stop) rto_left = -1;
      if (start) begin
        rto_left = (period != 0) ? int'(period) * TK : -1;
        rto_own  = int'(rsock);
      end
    end else if (rto_left > 0) begin
      rto_left--;
      if (rto_left == 0) begin tsock = rto_own; rto_left = -1; end
    end
    for (int n = 0; n < NS; n++) begin
      ev  = sevt[n*5 +: 5];
      if (tsock == n) ev[3] = 1'b1;
      clr = (we && addr == 3'(2 + n)) ? wdata[4:0] : 5'b0;
      m_sock[n] = ev | (m_sock[n] & ~clr);
    end
    m_net = nevt | (m_net & ~((we && addr == 3'd0) ? wdata[7:6] : 2'b00));
    if (we && addr == 3'd1) m_mask = wdata;
    m_int_n = !any;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic chk(input string tag);
    logic [19:0] es;
    for (int n = 0; n < NS; n++) es[n*5 +: 5] = m_sock[n];
    n_chk++;
    if (sstat !== es || cstat !== exp_com() || mask !== m_mask || int_n !== m_int_n) begin
      n_fail++;
      $display("FAIL %s: sock=%h com=%h mask=%h int_n=%b expected sock=%h com=%h mask=%h int_n=%b",
               tag, sstat, cstat, mask, int_n, es, exp_com(), m_mask, m_int_n);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int n = 0; n < NS; n++) m_sock[n] = '0;
    m_net = '0; m_mask = '0; m_int_n = 1'b1; rto_left = -1; rto_own = 0;
    idle();
    repeat (3) @(negedge clk);
    chk("R1 in reset");
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 after release");

    // R7: enable every source
    wr(3'd1, 8'hFF); chk("R7 mask load");

    // R2/R3/R4/R8: every socket, every event bit
    for (int n = 0; n < NS; n++) begin
      for (int b = 0; b < 5; b++) begin
        sevt[n*5 + b] = 1'b1; step(); chk("R2 event sets bit");
        step(); chk("R8 interrupt asserted");
        wr(3'(2 + n), ~(8'd1 << b)); chk("R3 other bits written");
        wr(3'(2 + n), 8'd1 << b);    chk("R3 bit cleared");
        step(); chk("R8 interrupt released");
        sevt[n*5 + b] = 1'b1; we = 1'b1; addr = 3'(2 + n); wdata = 8'd1 << b;
        step(); chk("R4 event beats clear");
        wr(3'(2 + n), 8'h1F); step(); chk("R3 full clear");
      end
    end

    // R5/R6: network flags and summary bits
    nevt = 2'b01; step(); chk("R5 unreachable bit 6");
    nevt = 2'b10; step(); chk("R5 conflict bit 7");
    sevt[2*5 + 1] = 1'b1; step(); chk("R6 summary for socket 2");
    wr(3'd0, 8'h0F); chk("R6 summary write ignored");
    wr(3'd0, 8'h40); chk("R5 clear unreachable only");
    nevt = 2'b10; we = 1'b1; addr = 3'd0; wdata = 8'h80; step(); chk("R5 event beats clear");
    wr(3'd0, 8'hC0); wr(3'(4), 8'h1F); step(); chk("R6 summary cleared");

    // R7/R8: sweep all masks against a fixed mix of set sources
    sevt[1*5 + 2] = 1'b1; sevt[3*5 + 0] = 1'b1; nevt = 2'b10; step();
    for (int m = 0; m < 256; m++) begin
      wr(3'd1, 8'(m)); chk("R7 mask sweep");
      step(); chk("R8 mask sweep");
    end
    wr(3'd0, 8'hC0); wr(3'd3, 8'h1F); wr(3'd5, 8'h1F);
    wr(3'd1, 8'hFF); step(); chk("R8 all clear");

    // R9: timer periods 1..4, checked every cycle
    for (int p = 1; p <= 4; p++) begin
      start = 1'b1; rsock = 2'(p % NS); period = PW'(p);
      step(); chk("R9 start");
      for (int k = 0; k < p * TK + 2; k++) begin step(); chk("R9 countdown"); end
      wr(3'(2 + (p % NS)), 8'h08); chk("R9 clear timeout");
    end

    // R10: stop, restart, zero period
    start = 1'b1; rsock = 2'd1; period = PW'(4); step();
    repeat (5) step();
    stop = 1'b1; step(); chk("R10 stop");
    for (int k = 0; k < 15; k++) begin step(); chk("R10 stopped stays quiet"); end
    start = 1'b1; rsock = 2'd2; period = PW'(2); step();
    repeat (3) step();
    start = 1'b1; rsock = 2'd0; period = PW'(2); step(); chk("R10 restart");
    for (int k = 0; k < 8; k++) begin step(); chk("R10 restarted count"); end
    wr(3'd2, 8'h08);
    start = 1'b1; rsock = 2'd3; period = '0; step();
    for (int k = 0; k < 20; k++) begin step(); chk("R10 zero period idle"); end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule